// File: doc/BRIEF.md
# Coprocessor Bus Cycle Controller

This block is the slave-side bus state machine of a math coprocessor on a host CPU bus. It follows every host bus cycle through three states: idle, a first state used only by overlapped (pipelined) cycles, and a wait state in which it listens for the system ready input. When a cycle starts it records the direction and the command-select input. It reports the decoded transfer type on `xfer_type`.

While selected, it drives an early, active-low ready-out pulse. For an ordinary write the pulse comes in the first wait state. For a read, or for a write flagged as an environment/state restore, it comes in the second wait state. During a selected write the data bus is captured on every falling clock edge for as long as the cycle waits.

State tracking runs whether or not the chip select is active, so the block stays in step with the host across bus cycles aimed at other devices.

Top module: `copro_bus_ctrl`

## Requirements
- R1: After reset the controller is idle, `rdy_out_n` is 1 and `data_q` is 0.
- R2: A strobe (`strobe_n`=0) sampled in idle starts a cycle. During the following clock `xfer_type` = {`wr_sel`, `cmd_sel`}: bit 1 is 1 for a write and 0 for a read; bit 0 is 1 for an operand or control/status transfer and 0 for an opcode transfer.
- R3: For a selected write with `restore`=0, `rdy_out_n` is 0 for exactly one clock, in the first wait state. This is the clock right after the strobe (or right after the pipelined first state).
- R4: For a selected read, or a selected write with `restore`=1, `rdy_out_n` is 0 for exactly one clock, in the second wait state, and is 1 in the first.
- R5: The controller stays in the wait state, one clock per wait state, until `sys_rdy_n`=0 is sampled. `rdy_out_n` is never asserted again within the same cycle.
- R6: A strobe sampled during the wait state, either before or on the terminating clock, is held pending. On termination the controller spends one clock in the pipelined first state and then enters the wait state with the pending cycle's attributes, which were taken when its strobe was sampled.
- R7: If no strobe is pending at termination, the controller returns to idle and stays there until a new strobe is sampled.
- R8: When `chip_sel`=0 at the cycle's strobe, `rdy_out_n` stays 1 and `data_q` is unchanged, but state tracking still advances.
- R9: In every wait-state clock of a selected write, `data_q` takes `data_in` at the falling clock edge. At all other times it holds.
- R10: `rdy_out_n` is 1 in idle and in the pipelined first state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_n | input | 1 | Active-low cycle-start strobe from host |
| chip_sel | input | 1 | Device selected for this cycle (active high) |
| wr_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_sel | input | 1 | 1 = operand/control transfer, 0 = opcode transfer |
| sys_rdy_n | input | 1 | Active-low system ready that terminates a cycle |
| restore | input | 1 | Marks a write as environment/state restore |
| data_in | input | 16 | Host data bus |
| rdy_out_n | output | 1 | Registered active-low early ready |
| data_q | output | 16 | Latched write data |
| xfer_type | output | 2 | Decoded transfer type of the current cycle |

## Verification
A strobe presented in one clock shows up as the decoded type and the first wait state in the next clock. Ready-out is due in that clock for an ordinary write and one clock later for reads and restore writes. A pipelined cycle adds one first-state clock after the terminating clock. Captured data is visible in the same clock as the falling edge that takes it. The bench drives inputs 1 ns after each rising edge and samples 1 ns before the next one, so every check reads the registered values of the clock whose inputs it just set. It sweeps direction, command select, restore flag, select, zero to three wait states, and pipelined or idle follow-on cycles, including strobes that arrive before the terminating clock.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PIPE = 2'd1,
    ST_WAIT = 2'd2
  } bus_st_e;

  typedef struct packed {
    logic wr;
    logic cmd;
    logic sel;
    logic rs;
  } cyc_attr_t;

  // transfer type: bit1 = write, bit0 = operand/control (0 = opcode)
  localparam logic [1:0] XF_OPC_RD  = 2'b00;
  localparam logic [1:0] XF_OPND_RD = 2'b01;
  localparam logic [1:0] XF_OPC_WR  = 2'b10;
  localparam logic [1:0] XF_OPND_WR = 2'b11;

endpackage

// File: rtl/cbc_cycle_tracker.sv
module cbc_cycle_tracker
  import cbc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             strb_i,
  input  logic             rdy_i,
  input  cyc_attr_t        in_attr_i,
  output bus_st_e          state_o,
  output bus_st_e          state_nxt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output cyc_attr_t        cur_o,
  output cyc_attr_t        cur_nxt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  bus_st_e          state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  cyc_attr_t        cur_q, cur_n;
  logic             pend_q, pend_n;
  cyc_attr_t        pattr_q, pattr_n;
  logic             upd_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cur_n   = cur_q;
    pend_n  = pend_q;
    pattr_n = pattr_q;
    case (state_q)
      ST_IDLE: begin
        if (strb_i) begin
          state_n = ST_WAIT;
          cnt_n   = '0;
          cur_n   = in_attr_i;
        end
      end
      ST_PIPE: begin
        state_n = ST_WAIT;
        cnt_n   = '0;
      end
      ST_WAIT: begin
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
        if (strb_i && !pend_q) begin
          pend_n  = 1'b1;
          pattr_n = in_attr_i;
        end
        if (rdy_i) begin
          if (pend_q || strb_i) begin
            state_n = ST_PIPE;
            cur_n   = pend_q ? pattr_q : in_attr_i;
          end else begin
            state_n = ST_IDLE;
          end
          pend_n = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign upd_en = (state_q != ST_IDLE) || strb_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      pend_q  <= 1'b0;
      pattr_q <= '0;
    end else if (upd_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      cur_q   <= cur_n;
      pend_q  <= pend_n;
      pattr_q <= pattr_n;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_n;
  assign cnt_o       = cnt_q;
  assign cnt_nxt_o   = cnt_n;
  assign cur_o       = cur_q;
  assign cur_nxt_o   = cur_n;

  // R6: the pipelined first state lasts one clock
  p_pipe_one_clk_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q == ST_PIPE |=> state_q == ST_WAIT);

  // R5: no termination without system ready
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WAIT && !rdy_i) |=> state_q == ST_WAIT);

  // R7: idle persists without a strobe
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && !strb_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/cbc_ready_gen.sv
module cbc_ready_gen
  import cbc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  bus_st_e          state_i,
  input  bus_st_e          state_nxt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  cyc_attr_t        cur_i,
  input  cyc_attr_t        cur_nxt_i,
  output logic             rdy_no
);

  logic [CNT_W-1:0] tgt_nxt;
  logic             rdy_d;
  logic             rdy_q;

  // ordinary writes answer in the first wait state, others in the second
  always_comb begin
    tgt_nxt = (cur_nxt_i.wr && !cur_nxt_i.rs) ? CNT_W'(0) : CNT_W'(1);
    rdy_d   = !((state_nxt_i == ST_WAIT) && cur_nxt_i.sel && (cnt_nxt_i == tgt_nxt));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b1;
    else         rdy_q <= rdy_d;
  end

  assign rdy_no = rdy_q;

  // R10: ready-out only while waiting
  p_rdy_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rdy_q |-> state_i == ST_WAIT);

  // R3: one-clock pulse
  p_rdy_single_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !rdy_q |=> rdy_q);

  // R8: never for an unselected cycle
  p_rdy_selected_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !rdy_q |-> cur_i.sel);

  // R4: reads and restore writes stay quiet in the first wait state
  p_rdy_late_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_i == ST_WAIT && cnt_i == '0 && (!cur_i.wr || cur_i.rs)) |-> rdy_q);

endmodule

// File: rtl/cbc_data_latch.sv
module cbc_data_latch
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  bus_st_e           state_i,
  input  cyc_attr_t         cur_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  logic              cap_en;
  logic [DATA_W-1:0] data_q;

  assign cap_en = (state_i == ST_WAIT) && cur_i.sel && cur_i.wr;

  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (cap_en) data_q <= data_i;
  end

  assign data_o = data_q;

  // R9: outside a selected write wait state the latch holds
  p_latch_hold_r9: assert property (@(negedge clk) disable iff (!rst_ni)
    !cap_en |=> $stable(data_q));

endmodule

// File: rtl/copro_bus_ctrl.sv
module copro_bus_ctrl
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              chip_sel,
  input  logic              wr_sel,
  input  logic              cmd_sel,
  input  logic              sys_rdy_n,
  input  logic              restore,
  input  logic [DATA_W-1:0] data_in,
  output logic              rdy_out_n,
  output logic [DATA_W-1:0] data_q,
  output logic [1:0]        xfer_type
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_s = rst_sync_q[SYNC_W-1];

  cyc_attr_t        in_attr;
  bus_st_e          state, state_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  cyc_attr_t        cur, cur_nxt;

  assign in_attr = '{wr: wr_sel, cmd: cmd_sel, sel: chip_sel, rs: restore};

  cbc_cycle_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk        (clk),
    .rst_ni     (rst_s),
    .strb_i     (!strobe_n),
    .rdy_i      (!sys_rdy_n),
    .in_attr_i  (in_attr),
    .state_o    (state),
    .state_nxt_o(state_nxt),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .cur_o      (cur),
    .cur_nxt_o  (cur_nxt)
  );

  cbc_ready_gen #(.CNT_W(CNT_W)) u_rdy (
    .clk        (clk),
    .rst_ni     (rst_s),
    .state_i    (state),
    .state_nxt_i(state_nxt),
    .cnt_i      (cnt),
    .cnt_nxt_i  (cnt_nxt),
    .cur_i      (cur),
    .cur_nxt_i  (cur_nxt),
    .rdy_no     (rdy_out_n)
  );

  cbc_data_latch #(.DATA_W(DATA_W)) u_dat (
    .clk    (clk),
    .rst_ni (rst_s),
    .state_i(state),
    .cur_i  (cur),
    .data_i (data_in),
    .data_o (data_q)
  );

  assign xfer_type = {cur.wr, cur.cmd};

  // R2: decode taken at the starting strobe
  p_decode_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (state == ST_IDLE && !strobe_n) |=> xfer_type == {$past(wr_sel), $past(cmd_sel)});

endmodule

// File: tb/tb_copro_bus_ctrl.sv
`timescale 1ns/100ps
module tb_copro_bus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_n, chip_sel, wr_sel, cmd_sel, sys_rdy_n, restore;
  logic [15:0] data_in;
  logic        rdy_out_n;
  logic [15:0] data_q;
  logic [1:0]  xfer_type;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] exp_data;

  always #2.5 clk = ~clk;

  copro_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .chip_sel(chip_sel),
    .wr_sel(wr_sel), .cmd_sel(cmd_sel), .sys_rdy_n(sys_rdy_n), .restore(restore),
    .data_in(data_in), .rdy_out_n(rdy_out_n), .data_q(data_q), .xfer_type(xfer_type)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // wait to the sample point, then move to the next drive point
  task automatic to_sample();
    #3;
  endtask
  task automatic to_drive();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    strobe_n = 1'b1; sys_rdy_n = 1'b1;
  endtask

  task automatic run_cycle(input bit wr, input bit cmd, input bit sel, input bit rs,
                           input int waits, input bit started, input bit pipe,
                           input bit nwr, input bit ncmd, input bit nsel, input bit nrs,
                           input logic [15:0] base);
    int tgt;
    int n;
    int sj;
    tgt = (wr && !rs) ? 0 : 1;
    n   = tgt + 1 + waits;
    sj  = (waits[0] && n > 1) ? n - 2 : n - 1;
    if (!started) begin
      strobe_n = 1'b0; wr_sel = wr; cmd_sel = cmd; chip_sel = sel; restore = rs;
      sys_rdy_n = 1'b1;
      to_sample();
      chk(rdy_out_n == 1'b1, "R10 idle start slot", rdy_out_n, 1);
      to_drive();
    end else begin
      quiet();
      to_sample();
      chk(rdy_out_n == 1'b1, "R10/R6 pipelined first slot", rdy_out_n, 1);
      to_drive();
    end
    for (int j = 0; j < n; j++) begin
      data_in   = base + 16'(j);
      sys_rdy_n = (j == n - 1) ? 1'b0 : 1'b1;
      if (pipe && j == sj) begin
        strobe_n = 1'b0; wr_sel = nwr; cmd_sel = ncmd; chip_sel = nsel; restore = nrs;
      end else begin
        strobe_n = 1'b1; wr_sel = ~nwr; cmd_sel = ~ncmd; chip_sel = ~nsel; restore = ~nrs;
      end
      to_sample();
      if (sel && wr) exp_data = base + 16'(j);
      if (j == 0)
        chk(xfer_type == {wr, cmd}, "R2 transfer type", xfer_type, {wr, cmd});
      if (sel && j == tgt)
        chk(rdy_out_n == 1'b0, (tgt == 0) ? "R3 early ready" : "R4 late ready", rdy_out_n, 0);
      else if (sel && j < tgt)
        chk(rdy_out_n == 1'b1, "R4 quiet first wait", rdy_out_n, 1);
      else if (sel)
        chk(rdy_out_n == 1'b1, "R5 no repeat ready", rdy_out_n, 1);
      else
        chk(rdy_out_n == 1'b1, "R8 unselected ready", rdy_out_n, 1);
      chk(data_q == exp_data, sel ? "R9 data capture" : "R8 data held", data_q, exp_data);
      to_drive();
    end
    quiet();
  endtask

  initial begin
    rst_n = 1'b0; quiet(); chip_sel = 1'b0; wr_sel = 1'b0; cmd_sel = 1'b0;
    restore = 1'b0; data_in = 16'h0;
    exp_data = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      to_drive();
      data_in = 16'hA5A5;
      to_sample();
      chk(rdy_out_n == 1'b1, "R1 reset ready", rdy_out_n, 1);
      chk(data_q == 16'h0, "R1 reset data", data_q, 0);
    end
    to_drive();
    begin
      bit started;
      started = 1'b0;
      for (int k = 0; k < 128; k++) begin
        bit pipe;
        int kn;
        kn   = k + 1;
        pipe = k[6] && (k != 127);
        run_cycle(k[0], k[1], !k[5], k[2], int'(k[4:3]), started, pipe,
                  kn[0], kn[1], !kn[5], kn[2], 16'(k * 16 + 16'h1000));
        started = pipe;
        if (!pipe) begin
          data_in = 16'hFFFF;
          to_sample();
          chk(rdy_out_n == 1'b1, "R7 idle after termination", rdy_out_n, 1);
          chk(data_q == exp_data, "R7 idle data held", data_q, exp_data);
          to_drive();
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule